// File: doc/BRIEF.md
# Gated Programmable Clock Divider

The block divides a fast source clock by a ratio chosen from a 4-bit code and one of two ratio tables, and drives a single group clock. The low two code bits pick a base factor and the high two bits multiply it by a power of two, so one table reaches even and odd ratios from /2 to /56 and the other from /3 to /72. Odd ratios use both edges of the source clock, which keeps the duty cycle at exactly 50%.

An invert input gives the output the opposite phase. An enable input and an active-low stop input both park the output low. The block never cuts a high phase short. The output restarts with a full high phase, aligned to the divider period boundary. A new code, table or invert setting is taken only at that boundary, so a reconfiguration never produces a runt pulse.

Top module: `clkdiv_gate`

## Requirements
- R1: While rst_ni is low the output is low and the divider counter is zero; with invert clear, the first rising edge of the output follows the second rising edge of clk_i after reset is released.
- R2: With tbl_sel_i=0 the ratio is B<<div_code_i[3:2], where div_code_i[1:0] = 0,1,2,3 gives B = 2,3,5,7 (/2 to /56).
- R3: With tbl_sel_i=1 the ratio is B<<div_code_i[3:2], where div_code_i[1:0] = 0,1,2,3 gives B = 4,3,5,9 (/3 to /72).
- R4: For every ratio N, the output period is 2N half-cycles of clk_i and its high phase is exactly N half-cycles, for odd N as well as even N.
- R5: With invert_i=1 the output is high where the non-inverted waveform is low: after reset it first rises floor(N/2) source cycles after the counter restart, plus half a cycle when N is odd.
- R6: A change of div_code_i, tbl_sel_i or invert_i takes effect at the next divider period boundary; the current high phase keeps its old width.
- R7: While stop_ni is low, the output finishes its current high phase at full width and then stays low.
- R8: While enable_i is low, the output finishes its current high phase at full width and then stays low.
- R9: After stop_ni and enable_i both return high, the output restarts at a counter restart and its first high phase has full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_code_i | input | 4 | Ratio code: [1:0] base factor, [3:2] power-of-two multiplier |
| tbl_sel_i | input | 1 | Ratio table select (0: bases 2,3,5,7; 1: bases 4,3,5,9) |
| invert_i | input | 1 | Phase inversion of the output |
| enable_i | input | 1 | Output enable; low parks the output low |
| stop_ni | input | 1 | Active-low stop request; low parks the output low |
| clk_o | output | 1 | Divided group clock |

## Verification
The assertions check several rules on every cycle: the counter stays below the active ratio, a new ratio is loaded only when the counter restarts, a non-inverted high phase begins only at a counter restart, and a held stop or disable keeps a parked output low. Other properties are visible only at the pin over whole periods, so the bench scenarios show them. These are the exact high and low widths for each table entry, the phase offset under inversion, the lack of a runt pulse when the code changes mid-period, and the full-width last and first high phases around a stop or a disable.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int BASE_W     = 2;
  localparam int BASE_VAL_W = 4;
  localparam int RST_RATIO  = 2;

  // base factor per table; entries 1 and 2 are shared
  function automatic logic [BASE_VAL_W-1:0] base_of(input logic [BASE_W-1:0] sel,
                                                    input logic tbl_b);
    logic [BASE_VAL_W-1:0] b;
    case (sel)
      2'd0:    b = tbl_b ? 4'd4 : 4'd2;
      2'd1:    b = 4'd3;
      2'd2:    b = 4'd5;
      default: b = tbl_b ? 4'd9 : 4'd7;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/clkdiv_ratio_dec.sv
module clkdiv_ratio_dec
  import clkdiv_pkg::*;
#(
  parameter int SHIFT_W = 2,
  localparam int CODE_W  = BASE_W + SHIFT_W,
  localparam int RATIO_W = BASE_VAL_W + (1 << SHIFT_W) - 1
) (
  input  logic [CODE_W-1:0]  code_i,
  input  logic               tbl_b_i,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [BASE_VAL_W-1:0] base;
  logic [SHIFT_W-1:0]    shamt;

  always_comb begin
    base    = base_of(code_i[BASE_W-1:0], tbl_b_i);
    shamt   = code_i[CODE_W-1:BASE_W];
    ratio_o = RATIO_W'(base) << shamt;
  end
endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_new_i,
  input  logic               invert_i,
  input  logic               stop_req_i,
  output logic               pos_lvl_o,
  output logic               odd_o,
  output logic               inv_o,
  output logic [RATIO_W-1:0] cnt_o,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [RATIO_W-1:0] ratio_q, ratio_nx, half_nx;
  logic               inv_q, inv_nx;
  logic               parked_q, parked_d;
  logic               lvl_q, lvl_d, wrap;

  always_comb begin
    wrap     = (cnt_q == ratio_q - RATIO_W'(1));
    cnt_d    = wrap ? '0 : cnt_q + RATIO_W'(1);
    ratio_nx = wrap ? ratio_new_i : ratio_q;
    inv_nx   = wrap ? invert_i : inv_q;
    half_nx  = ratio_nx >> 1;
    lvl_d    = inv_nx ^ (cnt_d < half_nx);
    // park only where the waveform is low, unpark only at a restart
    if (wrap && !stop_req_i)      parked_d = 1'b0;
    else if (stop_req_i && !lvl_d) parked_d = 1'b1;
    else                          parked_d = parked_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      ratio_q  <= RATIO_W'(RST_RATIO);
      inv_q    <= 1'b0;
      parked_q <= 1'b1;
      lvl_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      ratio_q  <= ratio_nx;
      inv_q    <= inv_nx;
      parked_q <= parked_d;
      lvl_q    <= lvl_d && !parked_d;
    end
  end

  assign pos_lvl_o = lvl_q;
  assign odd_o     = ratio_q[0];
  assign inv_o     = inv_q;
  assign cnt_o     = cnt_q;
  assign ratio_o   = ratio_q;
endmodule

// File: rtl/clkdiv_shaper.sv
module clkdiv_shaper (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_lvl_i,
  input  logic odd_i,
  input  logic inv_i,
  output logic clk_o
);
  logic neg_lvl_q;

  // half-cycle delayed copy gives the extra half high phase for odd ratios
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_lvl_q <= 1'b0;
    else         neg_lvl_q <= pos_lvl_i;
  end

  always_comb begin
    if (!odd_i)     clk_o = pos_lvl_i;
    else if (inv_i) clk_o = pos_lvl_i & neg_lvl_q;
    else            clk_o = pos_lvl_i | neg_lvl_q;
  end
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate
  import clkdiv_pkg::*;
#(
  parameter int SHIFT_W = 2,
  localparam int CODE_W  = BASE_W + SHIFT_W,
  localparam int RATIO_W = BASE_VAL_W + (1 << SHIFT_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              tbl_sel_i,
  input  logic              invert_i,
  input  logic              enable_i,
  input  logic              stop_ni,
  output logic              clk_o
);
  logic [RATIO_W-1:0] ratio_new, ratio_w, cnt_w;
  logic               pos_lvl_w, odd_w, inv_w, stop_req;

  assign stop_req = !stop_ni || !enable_i;

  clkdiv_ratio_dec #(.SHIFT_W(SHIFT_W)) i_dec (
    .code_i  (div_code_i),
    .tbl_b_i (tbl_sel_i),
    .ratio_o (ratio_new)
  );

  clkdiv_seq #(.RATIO_W(RATIO_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ratio_new_i (ratio_new),
    .invert_i    (invert_i),
    .stop_req_i  (stop_req),
    .pos_lvl_o   (pos_lvl_w),
    .odd_o       (odd_w),
    .inv_o       (inv_w),
    .cnt_o       (cnt_w),
    .ratio_o     (ratio_w)
  );

  clkdiv_shaper i_shp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pos_lvl_i (pos_lvl_w),
    .odd_i     (odd_w),
    .inv_i     (inv_w),
    .clk_o     (clk_o)
  );
endmodule

// File: rtl/clkdiv_gate_chk.sv
module clkdiv_gate_chk #(
  parameter int RATIO_W = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               stop_ni,
  input logic               enable_i,
  input logic               clk_o,
  input logic               pos_lvl,
  input logic               inv_q,
  input logic [RATIO_W-1:0] cnt_q,
  input logic [RATIO_W-1:0] ratio_q
);
  logic req;
  assign req = !stop_ni || !enable_i;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_low: assert (clk_o == 1'b0 && cnt_q == '0);
    end
  end

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);

  a_r2_ratio_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_q >= RATIO_W'(2));

  a_r6_load_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q != $past(ratio_q)) |-> (cnt_q == '0));

  a_r9_restart_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pos_lvl) && !inv_q) |-> (cnt_q == '0));

  a_r7_parked_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req) && !$past(pos_lvl) && req) |-> !pos_lvl);
endmodule

bind clkdiv_gate clkdiv_gate_chk #(.RATIO_W(RATIO_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stop_ni  (stop_ni),
  .enable_i (enable_i),
  .clk_o    (clk_o),
  .pos_lvl  (pos_lvl_w),
  .inv_q    (inv_w),
  .cnt_q    (cnt_w),
  .ratio_q  (ratio_w)
);

// File: tb/test_clkdiv_gate.sv
`timescale 1ns/1ps
module test_clkdiv_gate;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] div_code_i = 4'd0;
  logic       tbl_sel_i = 1'b0;
  logic       invert_i = 1'b0;
  logic       enable_i = 1'b1;
  logic       stop_ni = 1'b1;
  logic       clk_o;

  int n_chk = 0, n_fail = 0, mon_done = 0;
  bit finished = 0;
  int    exp_n[$];
  string exp_tag[$];

  always #2.5 clk_i = ~clk_i;

  clkdiv_gate i_clkdiv_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_code_i(div_code_i), .tbl_sel_i(tbl_sel_i),
    .invert_i(invert_i), .enable_i(enable_i), .stop_ni(stop_ni), .clk_o(clk_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // one sample per clock edge, 1 ns after it
  task automatic half();
    @(posedge clk_i or negedge clk_i);
    #1;
  endtask

  task automatic wait_rise();
    bit prv;
    half();
    prv = clk_o;
    for (int g = 0; g < 1000; g++) begin
      half();
      if (!prv && clk_o) return;
      prv = clk_o;
    end
  endtask

  // counts samples at lvl, current sample included
  task automatic count_level(input bit lvl, output int n);
    n = 1;
    for (int g = 0; g < 1000; g++) begin
      half();
      if (clk_o == lvl) n++;
      else return;
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      int n, hi, lo;
      string tag;
      wait (exp_n.size() != 0);
      n = exp_n.pop_front();
      tag = exp_tag.pop_front();
      wait_rise();
      count_level(1'b1, hi);
      count_level(1'b0, lo);
      chk(hi == n, {tag, " R4 high width"}, hi, n);
      chk(hi + lo == 2 * n, {tag, " period"}, hi + lo, 2 * n);
      mon_done++;
    end
  end

  task automatic reset_phase(input logic [3:0] code, input logic tb, input logic inv,
                             input int exp_idx, input string tag);
    int idx;
    div_code_i = code; tbl_sel_i = tb; invert_i = inv;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk(clk_o == 1'b0, "R1 low in reset", clk_o, 0);
    @(negedge clk_i);
    #0.5 rst_ni = 1'b1;
    idx = 0;
    for (int g = 0; g < 400; g++) begin
      half();
      idx++;
      if (clk_o) break;
    end
    chk(idx == exp_idx, tag, idx, exp_idx);
  endtask

  task automatic push_cfg(input logic [3:0] code, input logic tb, input logic inv,
                          input int n, input string tag);
    int k;
    div_code_i = code; tbl_sel_i = tb; invert_i = inv;
    repeat (4 * n + 150) @(posedge clk_i);
    k = mon_done;
    exp_n.push_back(n);
    exp_tag.push_back(tag);
    wait (mon_done == k + 1);
  endtask

  task automatic park_test(input bit use_en, input int n, input string tag);
    int hi, highs;
    wait_rise();
    if (use_en) enable_i = 1'b0; else stop_ni = 1'b0;
    count_level(1'b1, hi);
    chk(hi == n, {tag, " last high full"}, hi, n);
    highs = 0;
    for (int g = 0; g < 60; g++) begin
      half();
      if (clk_o) highs++;
    end
    chk(highs == 0, {tag, " parked low"}, highs, 0);
    enable_i = 1'b1; stop_ni = 1'b1;
    wait_rise();
    count_level(1'b1, hi);
    chk(hi == n, "R9 first high full", hi, n);
  endtask

  initial begin
    int hi, lo, hi2;
    // R1 non-inverted /2, R5 inverted /4 and /3
    reset_phase(4'd0, 1'b0, 1'b0, 3, "R1 first rise");
    reset_phase(4'd0, 1'b1, 1'b1, 7, "R5 inverted even first rise");
    reset_phase(4'd1, 1'b0, 1'b1, 6, "R5 inverted odd first rise");

    push_cfg(4'd0,  1'b0, 1'b0, 2,  "R2 /2");
    push_cfg(4'd1,  1'b0, 1'b0, 3,  "R2 /3");
    push_cfg(4'd6,  1'b0, 1'b0, 10, "R2 /10");
    push_cfg(4'd15, 1'b0, 1'b0, 56, "R2 /56");
    push_cfg(4'd0,  1'b1, 1'b0, 4,  "R3 /4");
    push_cfg(4'd3,  1'b1, 1'b0, 9,  "R3 /9");
    push_cfg(4'd13, 1'b1, 1'b0, 24, "R3 /24");
    push_cfg(4'd15, 1'b1, 1'b0, 72, "R3 /72");
    push_cfg(4'd5,  1'b1, 1'b1, 6,  "R5 inverted /6");
    push_cfg(4'd2,  1'b0, 1'b1, 5,  "R5 inverted /5");
    push_cfg(4'd7,  1'b0, 1'b1, 14, "R5 inverted /14");

    // R6: switch /2 -> /7 during a high phase
    div_code_i = 4'd0; tbl_sel_i = 1'b0; invert_i = 1'b0;
    repeat (40) @(posedge clk_i);
    wait_rise();
    div_code_i = 4'd3;
    count_level(1'b1, hi);
    count_level(1'b0, lo);
    count_level(1'b1, hi2);
    chk(hi == 2, "R6 old high kept", hi, 2);
    chk(lo == 2, "R6 old low kept", lo, 2);
    chk(hi2 == 7, "R6 new ratio at boundary", hi2, 7);

    // R7 stop on /4, R8 disable on /5
    div_code_i = 4'd0; tbl_sel_i = 1'b1;
    repeat (60) @(posedge clk_i);
    park_test(1'b0, 4, "R7");
    div_code_i = 4'd2; tbl_sel_i = 1'b0;
    repeat (60) @(posedge clk_i);
    park_test(1'b1, 5, "R8");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule